// File: doc/BRIEF.md
# Cellular GA Offspring Datapath

This block is the reproduction stage of one processing element in a cellular genetic algorithm array. On a cycle where `in_valid` is high, it takes the element's own individual and its four grid neighbours (north, south, east, west), each with a fitness score. It picks two parents with a cascaded tournament. It recombines the parents with a two-cut crossover built from a contiguous mask and AND/OR gating, and mutates each child gene by gene from supplied random fields. It then scores both children with a replaceable one-cycle fitness unit.

The child with the higher score is registered and presented one clock later, together with its score, for the temporary population store. Selection, mask generation, crossover and mutation are purely combinational. The only register stage is the output register. The random bits come from outside the block, and so do the neighbour chromosomes.

The default fitness unit counts the ones in the chromosome. With the default 64-bit chromosome the score therefore runs from 0 to 64 and needs a 7-bit score width.

Top module: `cga_operator_dp`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_chrom` and `out_fit` are all zero.
- R2: `out_valid` in each cycle equals `in_valid` of the previous cycle. After a cycle with `in_valid` low, `out_chrom` and `out_fit` keep their values.
- R3: The first parent is the candidate with the highest fitness among the five slots. Slot order is current=0, north=1, south=2, east=3, west=4, and a tie goes to the lower slot number.
- R4: The second parent is the highest-fitness candidate among the four slots left after removing the first parent. Ties follow the same slot order.
- R5: The crossover mask sets bit i when lo ≤ i ≤ hi, where lo is the smaller and hi the larger of `cut_a` and `cut_b`. Equal cuts give a single set bit.
- R6: Child 0 takes the first parent's bits where the mask is 0 and the second parent's bits where the mask is 1. Child 1 takes the opposite bits.
- R7: With L = log2(N), gene i of child k is inverted exactly when the field `mut_rnd_k[i*L +: L]` is all zero. Any nonzero field, including a single set bit in any position, leaves the gene unchanged.
- R8: `out_fit` equals the number of ones in `out_chrom`.
- R9: The registered child is the one with the larger fitness. When the two scores are equal, child 0 is registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Candidates and random inputs are valid this cycle |
| cur_chrom | input | N | Element's own individual |
| cur_fit | input | FW | Fitness of own individual |
| north_chrom | input | N | North neighbour |
| north_fit | input | FW | North fitness |
| south_chrom | input | N | South neighbour |
| south_fit | input | FW | South fitness |
| east_chrom | input | N | East neighbour |
| east_fit | input | FW | East fitness |
| west_chrom | input | N | West neighbour |
| west_fit | input | FW | West fitness |
| cut_a | input | log2(N) | First random cut point |
| cut_b | input | log2(N) | Second random cut point |
| mut_rnd0 | input | N*log2(N) | Mutation fields for child 0 |
| mut_rnd1 | input | N*log2(N) | Mutation fields for child 1 |
| out_valid | output | 1 | Registered offspring valid |
| out_chrom | output | N | Fittest offspring |
| out_fit | output | FW | Fitness of `out_chrom` |

## Verification
The bench feeds cut pairs given in reverse order, so a design that does not swap them would build an empty mask and return a parent unchanged. It also feeds equal cuts at both ends of the word, where an exclusive bound would drop the single swapped bit. Fitness ties among candidates check slot-order priority, because a design that resolves ties toward the higher slot would pick a different parent. A directed case gives both children equal scores, so a design that prefers child 1 on ties fails it. Nonzero mutation fields walk a single set bit through every position, so a mutation test that looks at only part of the field flips genes it should leave alone. A hold cycle checks that idle inputs do not disturb the registered result.

// File: rtl/cga_pkg.sv
package cga_pkg;
    localparam int NUM_SLOTS = 5;

    typedef enum logic [2:0] {
        SLOT_CUR   = 3'd0,
        SLOT_NORTH = 3'd1,
        SLOT_SOUTH = 3'd2,
        SLOT_EAST  = 3'd3,
        SLOT_WEST  = 3'd4
    } slot_e;
endpackage

// File: rtl/cga_tournament.sv
module cga_tournament
    import cga_pkg::*;
#(
    parameter int N  = 64,
    parameter int FW = 7
) (
    input  logic [N-1:0]  cand_chrom [NUM_SLOTS],
    input  logic [FW-1:0] cand_fit   [NUM_SLOTS],
    output logic [N-1:0]  par_a,
    output logic [N-1:0]  par_b,
    output slot_e         idx_a,
    output slot_e         idx_b
);
    logic [2:0] win_a;
    logic [2:0] win_b;

    // first stage of the cascade: strict compare keeps the earlier slot on ties
    always_comb begin
        win_a = 3'd0;
        for (int k = 1; k < NUM_SLOTS; k++) begin
            if (cand_fit[k] > cand_fit[win_a]) win_a = 3'(k);
        end
    end

    // second stage skips the first winner
    always_comb begin
        win_b = (win_a == 3'd0) ? 3'd1 : 3'd0;
        for (int k = 0; k < NUM_SLOTS; k++) begin
            if ((3'(k) != win_a) && (cand_fit[k] > cand_fit[win_b])) win_b = 3'(k);
        end
    end

    assign par_a = cand_chrom[win_a];
    assign par_b = cand_chrom[win_b];
    assign idx_a = slot_e'(win_a);
    assign idx_b = slot_e'(win_b);
endmodule

// File: rtl/cga_xover.sv
module cga_xover #(
    parameter int N  = 64,
    localparam int CW = $clog2(N)
) (
    input  logic [N-1:0]  par_a,
    input  logic [N-1:0]  par_b,
    input  logic [CW-1:0] cut_a,
    input  logic [CW-1:0] cut_b,
    output logic [N-1:0]  kid0,
    output logic [N-1:0]  kid1
);
    logic [CW-1:0] lo;
    logic [CW-1:0] hi;
    logic [N-1:0]  mask;

    assign lo = (cut_a <= cut_b) ? cut_a : cut_b;
    assign hi = (cut_a <= cut_b) ? cut_b : cut_a;

    generate
        for (genvar i = 0; i < N; i++) begin : g_mask
            assign mask[i] = (CW'(i) >= lo) && (CW'(i) <= hi);
        end
    endgenerate

    assign kid0 = (par_a & ~mask) | (par_b & mask);
    assign kid1 = (par_b & ~mask) | (par_a & mask);
endmodule

// File: rtl/cga_mutate.sv
module cga_mutate #(
    parameter int N = 64,
    localparam int L = $clog2(N)
) (
    input  logic [N-1:0]   kid_in,
    input  logic [N*L-1:0] rnd,
    output logic [N-1:0]   kid_out
);
    generate
        for (genvar g = 0; g < N; g++) begin : g_gene
            assign kid_out[g] = kid_in[g] ^ (rnd[g*L +: L] == '0);
        end
    endgenerate
endmodule

// File: rtl/cga_fit_ones.sv
module cga_fit_ones #(
    parameter int N  = 64,
    parameter int FW = 7
) (
    input  logic [N-1:0]  chrom,
    output logic [FW-1:0] fit
);
    always_comb begin
        fit = '0;
        for (int i = 0; i < N; i++) fit = fit + FW'(chrom[i]);
    end
endmodule

// File: rtl/cga_operator_dp.sv
module cga_operator_dp
    import cga_pkg::*;
#(
    parameter int N  = 64,
    parameter int FW = $clog2(N + 1),
    localparam int CW = $clog2(N),
    localparam int RW = N * $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [N-1:0]  cur_chrom,
    input  logic [FW-1:0] cur_fit,
    input  logic [N-1:0]  north_chrom,
    input  logic [FW-1:0] north_fit,
    input  logic [N-1:0]  south_chrom,
    input  logic [FW-1:0] south_fit,
    input  logic [N-1:0]  east_chrom,
    input  logic [FW-1:0] east_fit,
    input  logic [N-1:0]  west_chrom,
    input  logic [FW-1:0] west_fit,
    input  logic [CW-1:0] cut_a,
    input  logic [CW-1:0] cut_b,
    input  logic [RW-1:0] mut_rnd0,
    input  logic [RW-1:0] mut_rnd1,
    output logic          out_valid,
    output logic [N-1:0]  out_chrom,
    output logic [FW-1:0] out_fit
);
    logic [N-1:0]  cand_chrom [NUM_SLOTS];
    logic [FW-1:0] cand_fit   [NUM_SLOTS];
    logic [N-1:0]  par_a;
    logic [N-1:0]  par_b;
    slot_e         sel_a_idx;
    slot_e         sel_b_idx;
    logic [N-1:0]  kid_raw [2];
    logic [N-1:0]  kid_mut [2];
    logic [FW-1:0] kid_fit [2];
    logic [RW-1:0] kid_rnd [2];
    logic          take_one;

    assign cand_chrom[SLOT_CUR]   = cur_chrom;
    assign cand_chrom[SLOT_NORTH] = north_chrom;
    assign cand_chrom[SLOT_SOUTH] = south_chrom;
    assign cand_chrom[SLOT_EAST]  = east_chrom;
    assign cand_chrom[SLOT_WEST]  = west_chrom;
    assign cand_fit[SLOT_CUR]     = cur_fit;
    assign cand_fit[SLOT_NORTH]   = north_fit;
    assign cand_fit[SLOT_SOUTH]   = south_fit;
    assign cand_fit[SLOT_EAST]    = east_fit;
    assign cand_fit[SLOT_WEST]    = west_fit;
    assign kid_rnd[0]             = mut_rnd0;
    assign kid_rnd[1]             = mut_rnd1;

    cga_tournament #(.N(N), .FW(FW)) u_sel (
        .cand_chrom (cand_chrom),
        .cand_fit   (cand_fit),
        .par_a      (par_a),
        .par_b      (par_b),
        .idx_a      (sel_a_idx),
        .idx_b      (sel_b_idx)
    );

    cga_xover #(.N(N)) u_xov (
        .par_a (par_a),
        .par_b (par_b),
        .cut_a (cut_a),
        .cut_b (cut_b),
        .kid0  (kid_raw[0]),
        .kid1  (kid_raw[1])
    );

    generate
        for (genvar c = 0; c < 2; c++) begin : g_kid
            cga_mutate #(.N(N)) u_mut (
                .kid_in  (kid_raw[c]),
                .rnd     (kid_rnd[c]),
                .kid_out (kid_mut[c])
            );
            cga_fit_ones #(.N(N), .FW(FW)) u_fit (
                .chrom (kid_mut[c]),
                .fit   (kid_fit[c])
            );
        end
    endgenerate

    assign take_one = kid_fit[1] > kid_fit[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_chrom <= '0;
            out_fit   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_chrom <= take_one ? kid_mut[1] : kid_mut[0];
                out_fit   <= take_one ? kid_fit[1] : kid_fit[0];
            end
        end
    end
endmodule

// File: rtl/cga_operator_dp_chk.sv
module cga_operator_dp_chk
    import cga_pkg::*;
#(
    parameter int N  = 64,
    parameter int FW = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              out_valid,
    input logic [N-1:0]      out_chrom,
    input logic [FW-1:0]     out_fit,
    input logic [5*FW-1:0]   fits,
    input slot_e             idx_a,
    input slot_e             idx_b,
    input logic [FW-1:0]     kf0,
    input logic [FW-1:0]     kf1
);
    logic a_is_max;
    logic b_is_next;

    always_comb begin
        a_is_max  = 1'b1;
        b_is_next = (idx_a != idx_b);
        for (int k = 0; k < NUM_SLOTS; k++) begin
            if (fits[k*FW +: FW] > fits[int'(idx_a)*FW +: FW]) a_is_max = 1'b0;
            if ((k != int'(idx_a)) && (fits[k*FW +: FW] > fits[int'(idx_b)*FW +: FW]))
                b_is_next = 1'b0;
        end
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_chrom == '0 && out_fit == '0));

    a_r2_valid_track: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r2_idle_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_chrom) && $stable(out_fit)));

    a_r3_first_parent: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> a_is_max);

    a_r4_second_parent: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> b_is_next);

    a_r8_fit_count: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_fit == FW'($countones(out_chrom))));

    a_r9_best_kept: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_fit >= $past(kf0) && out_fit >= $past(kf1)));
endmodule

bind cga_operator_dp cga_operator_dp_chk #(.N(N), .FW(FW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_chrom (out_chrom),
    .out_fit   (out_fit),
    .fits      ({west_fit, east_fit, south_fit, north_fit, cur_fit}),
    .idx_a     (sel_a_idx),
    .idx_b     (sel_b_idx),
    .kf0       (kid_fit[0]),
    .kf1       (kid_fit[1])
);

// File: tb/cga_operator_dp_tb.sv
`timescale 1ns/1ps
module cga_operator_dp_tb;
    localparam int N  = 64;
    localparam int L  = 6;
    localparam int FW = 7;
    localparam int NV = 8;

    localparam logic [N-1:0] BASE [5] = '{
        64'h0123_4567_89AB_CDEF, 64'hFFFF_0000_FFFF_0000, 64'hAAAA_AAAA_5555_5555,
        64'h0F0F_0F0F_0F0F_0F0F, 64'h1357_9BDF_0246_8ACE };

    localparam logic [FW-1:0] VF [NV][5] = '{
        '{7'd10, 7'd20, 7'd30, 7'd40, 7'd50},
        '{7'd50, 7'd40, 7'd30, 7'd20, 7'd10},
        '{7'd33, 7'd33, 7'd33, 7'd33, 7'd33},
        '{7'd7,  7'd60, 7'd60, 7'd2,  7'd2 },
        '{7'd0,  7'd0,  7'd0,  7'd0,  7'd64},
        '{7'd12, 7'd12, 7'd40, 7'd40, 7'd1 },
        '{7'd3,  7'd9,  7'd9,  7'd9,  7'd9 },
        '{7'd64, 7'd63, 7'd64, 7'd1,  7'd1 } };
    localparam logic [5:0] VCA [NV] = '{6'd0, 6'd40, 6'd5, 6'd63, 6'd0, 6'd10, 6'd31, 6'd17};
    localparam logic [5:0] VCB [NV] = '{6'd63, 6'd8, 6'd5, 6'd63, 6'd0, 6'd50, 6'd32, 6'd3};
    localparam logic [N-1:0] VFL0 [NV] = '{
        64'h0, 64'h0, 64'h0, 64'h8000_0000_0000_0001, 64'h0,
        64'h0000_0000_FFFF_FFFF, 64'h1234_0000_00F0_0401, 64'h0};
    localparam logic [N-1:0] VFL1 [NV] = '{
        64'h0, 64'h0, 64'h0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF,
        64'h0, 64'h0000_8888_0000_1111, 64'h4000_0000_0000_0002};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [N-1:0]  chr [5];
    logic [FW-1:0] fv  [5];
    logic [5:0]    cut_a = '0;
    logic [5:0]    cut_b = '0;
    logic [N-1:0]  fl0 = '0;
    logic [N-1:0]  fl1 = '0;
    logic [N*L-1:0] rnd0;
    logic [N*L-1:0] rnd1;
    logic          out_valid;
    logic [N-1:0]  out_chrom;
    logic [FW-1:0] out_fit;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    function automatic logic [N*L-1:0] mk_rnd(input logic [N-1:0] flip);
        logic [N*L-1:0] r;
        for (int i = 0; i < N; i++) r[i*L +: L] = flip[i] ? '0 : L'(1 << (i % L));
        return r;
    endfunction

    assign rnd0 = mk_rnd(fl0);
    assign rnd1 = mk_rnd(fl1);

    cga_operator_dp u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .cur_chrom(chr[0]), .cur_fit(fv[0]),
        .north_chrom(chr[1]), .north_fit(fv[1]),
        .south_chrom(chr[2]), .south_fit(fv[2]),
        .east_chrom(chr[3]), .east_fit(fv[3]),
        .west_chrom(chr[4]), .west_fit(fv[4]),
        .cut_a(cut_a), .cut_b(cut_b),
        .mut_rnd0(rnd0), .mut_rnd1(rnd1),
        .out_valid(out_valid), .out_chrom(out_chrom), .out_fit(out_fit)
    );

    task automatic chk(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // reference: rank by (fitness, lower slot), then mask, swap, flip, score
    function automatic logic [N+FW-1:0] model();
        int key [5];
        int a, b, lo, hi, p0, p1;
        logic [N-1:0] c0, c1;
        for (int k = 0; k < 5; k++) key[k] = int'(fv[k]) * 8 + (4 - k);
        a = 0;
        for (int k = 0; k < 5; k++) if (key[k] > key[a]) a = k;
        b = (a == 0) ? 1 : 0;
        for (int k = 0; k < 5; k++) if (k != a && key[k] > key[b]) b = k;
        lo = (cut_a < cut_b) ? int'(cut_a) : int'(cut_b);
        hi = (cut_a < cut_b) ? int'(cut_b) : int'(cut_a);
        for (int i = 0; i < N; i++) begin
            c0[i] = (i >= lo && i <= hi) ? chr[b][i] : chr[a][i];
            c1[i] = (i >= lo && i <= hi) ? chr[a][i] : chr[b][i];
        end
        c0 = c0 ^ fl0;
        c1 = c1 ^ fl1;
        p0 = $countones(c0);
        p1 = $countones(c1);
        return (p1 > p0) ? {c1, FW'(p1)} : {c0, FW'(p0)};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [N+FW-1:0] exp_v;
        logic [N-1:0]    held;
        for (int k = 0; k < 5; k++) begin
            chr[k] = BASE[k];
            fv[k]  = '0;
        end
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid in reset", 64'(out_valid), 64'h0);
        chk(out_chrom == '0, "R1 chrom in reset", out_chrom, 64'h0);
        chk(out_fit == '0, "R1 fit in reset", 64'(out_fit), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk
        for (int v = 0; v < NV; v++) begin
            for (int k = 0; k < 5; k++) fv[k] = VF[v][k];
            cut_a = VCA[v];
            cut_b = VCB[v];
            fl0 = VFL0[v];
            fl1 = VFL1[v];
            in_valid = 1'b1;
            exp_v = model();
            @(negedge clk);
            chk(out_valid == 1'b1, "R2 valid after input", 64'(out_valid), 64'h1);
            chk(out_chrom == exp_v[N+FW-1:FW], "R3 R4 R5 R6 R7 R9 offspring", out_chrom, exp_v[N+FW-1:FW]);
            chk(out_fit == exp_v[FW-1:0], "R8 R9 score", 64'(out_fit), 64'(exp_v[FW-1:0]));
        end

        // idle cycle must not disturb the result
        held = out_chrom;
        in_valid = 1'b0;
        chr[0] = ~chr[0];
        fv[0] = 7'd64;
        cut_a = 6'd1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R2 valid drops when idle", 64'(out_valid), 64'h0);
        chk(out_chrom == held, "R2 chrom held when idle", out_chrom, held);

        // equal child scores: child 0 wins
        chr[0] = 64'h0F;
        chr[1] = 64'hF0;
        fv[0] = 7'd5; fv[1] = 7'd4; fv[2] = 7'd0; fv[3] = 7'd0; fv[4] = 7'd0;
        cut_a = 6'd7;
        cut_b = 6'd0;
        fl0 = '0;
        fl1 = '0;
        in_valid = 1'b1;
        @(negedge clk);
        chk(out_chrom == 64'hF0, "R9 tie keeps child 0", out_chrom, 64'hF0);
        chk(out_fit == 7'd4, "R8 tie score", 64'(out_fit), 64'd4);

        // reset during operation
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk(out_chrom == '0 && out_fit == '0 && !out_valid, "R1 mid-run reset",
            out_chrom, 64'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule